// File: doc/BRIEF.md
# Slotted Random Backoff Channel Access Controller

This block decides when a wireless station may put a frame on a shared medium under carrier-sense multiple access with collision avoidance. When a frame is pending, the controller first waits until the medium has been quiet for a full distributed interframe spacing (DIFS). It then counts down a random number of idle slot periods and grants the transmitter access for exactly one clock cycle. Once the transmitter reports that the frame has gone out, the controller opens an acknowledgement window. An acknowledgement that arrives inside the window ends the exchange. If the window closes with no acknowledgement, the frame is treated as lost and the controller contends again with a wider window.

The contention window always has the form 2^n - 1. It starts at 15. Each consecutive loss grows it to 2*CW + 1, up to a ceiling of 1023, and a success returns it to 15. The random backoff is drawn from an external pseudo-random word masked with the current window, and a draw of zero is forced to one. A retry limit bounds the number of consecutive failed attempts; when it is reached the frame is abandoned and the window is reset. All interframe spacings and the slot length are parameters counted in clock cycles.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: While and right after reset, tx_grant, ack_timeout and tx_drop are 0 and cw_o equals 15.
- R2: A frame_req sampled high while the controller is idle, with the channel idle throughout, produces tx_grant in the cycle that follows the clock edge DIFS_CYC + N*SLOT_CYC edges after the edge that sampled the request. N is the backoff drawn at that edge.
- R3: A busy channel during the DIFS wait restarts it. The wait completes DIFS_CYC edges after the last edge that sampled chan_busy high.
- R4: A busy channel during backoff freezes the remaining slot count and discards the slot in progress. Counting resumes only after a fresh full DIFS of idle, and a grant is only issued when chan_busy was sampled low at the granting edge.
- R5: The backoff N equals rnd_i AND cw_o (bitwise). A result of 0 is replaced by 1.
- R6: tx_grant is high for exactly one cycle per grant and never together with ack_timeout.
- R7: Counting from the edge that samples tx_done as edge 0, an ack_rx sampled at edge j is accepted only when SIFS_CYC <= j <= SIFS_CYC + ACK_TO_CYC. An ack_rx sampled earlier is ignored.
- R8: With no accepted acknowledgement, ack_timeout pulses for one cycle after edge SIFS_CYC + ACK_TO_CYC. At that edge cw_o becomes 2*cw_o + 1, and a new attempt (DIFS, then a new backoff drawn with the grown window) starts.
- R9: cw_o never exceeds 1023. Growth beyond it saturates at 1023.
- R10: An accepted acknowledgement returns cw_o to 15 and the controller to idle.
- R11: On the RETRY_LIMIT-th consecutive timeout, tx_drop pulses in the same cycle as ack_timeout, cw_o returns to 15, and the controller goes idle with no further grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_busy | input | 1 | Medium busy indication, 1 = busy |
| frame_req | input | 1 | A frame is waiting to be sent |
| tx_done | input | 1 | Pulse: the granted frame has finished transmitting |
| ack_rx | input | 1 | Pulse: an acknowledgement was received |
| rnd_i | input | CW_W | Pseudo-random word for the backoff draw |
| tx_grant | output | 1 | One-cycle pulse: transmission may start |
| ack_timeout | output | 1 | One-cycle pulse: acknowledgement window closed with no acknowledgement |
| tx_drop | output | 1 | One-cycle pulse: retry limit reached, frame abandoned |
| cw_o | output | CW_W | Current contention window |

## Verification
Every result is a registered pulse. A grant arrives DIFS_CYC + N*SLOT_CYC edges after the request edge, or after the last busy edge plus the remaining slots when the channel interrupts. A timeout arrives SIFS_CYC + ACK_TO_CYC edges after the tx_done edge, and the next grant follows it after DIFS_CYC + N*SLOT_CYC more edges. For each stimulus the driver computes the edge number of every expected pulse and queues it together with the expected pulse pattern. The monitor samples on falling edges and compares each pulse it sees against the head of the queue, both pattern and cycle. The window value is read on the falling edge after the edge that changed it.

// File: rtl/csma_bo_pkg.sv
package csma_bo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIFS,
        ST_BACKOFF,
        ST_TXWAIT,
        ST_ACKWAIT
    } csma_state_e;

    typedef enum logic [1:0] {
        CW_HOLD,
        CW_RESET,
        CW_GROW
    } cw_op_e;

    typedef struct packed {
        logic drop;
        logic tmo;
        logic grant;
    } csma_pulse_t;

endpackage

// File: rtl/csma_idle_timer.sv
module csma_idle_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic busy,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // done marks the edge that completes LIMIT consecutive idle cycles
    assign done = !clr && !busy && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr || busy) begin
            cnt_q <= '0;
        end else if (cnt_q == TOP) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/csma_ack_window.sv
module csma_ack_window #(
    parameter int SIFS_CYC   = 16,
    parameter int ACK_TO_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic open_win,
    output logic expire
);
    localparam int LIM = SIFS_CYC + ACK_TO_CYC;
    localparam int W   = $clog2(LIM + 1);
    localparam logic [W-1:0] LIM_V  = W'(LIM);
    localparam logic [W-1:0] SIFS_V = W'(SIFS_CYC);

    logic [W-1:0] cnt_q;

    // cnt_q holds the number of edges since the tx_done edge
    assign open_win = (cnt_q >= SIFS_V);
    assign expire   = (cnt_q == LIM_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= W'(1);
        end else if (cnt_q != LIM_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/csma_backoff_cnt.sv
module csma_backoff_cnt #(
    parameter int CW_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [CW_W-1:0] rnd,
    input  logic [CW_W-1:0] mask,
    input  logic            dec,
    output logic            last
);
    logic [CW_W-1:0] bo_q;
    logic [CW_W-1:0] draw;

    always_comb begin
        draw = rnd & mask;
        if (draw == '0) begin
            draw = CW_W'(1);
        end
    end

    assign last = (bo_q == CW_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bo_q <= CW_W'(1);
        end else if (load) begin
            bo_q <= draw;
        end else if (dec && !last) begin
            bo_q <= bo_q - 1'b1;
        end
    end
endmodule

// File: rtl/csma_cw_reg.sv
module csma_cw_reg
    import csma_bo_pkg::*;
#(
    parameter int CW_W        = 10,
    parameter int CW_MIN      = 15,
    parameter int CW_MAX      = 1023,
    parameter int RETRY_LIMIT = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  cw_op_e          op,
    output logic [CW_W-1:0] cw,
    output logic [CW_W-1:0] cw_grown,
    output logic            last_try
);
    localparam int RW = $clog2(RETRY_LIMIT + 1);
    localparam logic [CW_W-1:0] MIN_V  = CW_W'(CW_MIN);
    localparam logic [CW_W-1:0] MAX_V  = CW_W'(CW_MAX);
    localparam logic [CW_W:0]   MAX_X  = (CW_W+1)'(CW_MAX);
    localparam logic [RW-1:0]   LAST_V = RW'(RETRY_LIMIT - 1);

    logic [CW_W-1:0] cw_q;
    logic [RW-1:0]   retry_q;
    logic [CW_W:0]   dbl;

    assign dbl      = {cw_q, 1'b1};
    assign cw_grown = (dbl > MAX_X) ? MAX_V : dbl[CW_W-1:0];
    assign cw       = cw_q;
    assign last_try = (retry_q == LAST_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q    <= MIN_V;
            retry_q <= '0;
        end else begin
            case (op)
                CW_RESET: begin
                    cw_q    <= MIN_V;
                    retry_q <= '0;
                end
                CW_GROW: begin
                    cw_q    <= cw_grown;
                    retry_q <= retry_q + 1'b1;
                end
                default: begin
                    cw_q    <= cw_q;
                    retry_q <= retry_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl
    import csma_bo_pkg::*;
#(
    parameter int DIFS_CYC    = 34,
    parameter int SIFS_CYC    = 16,
    parameter int SLOT_CYC    = 9,
    parameter int ACK_TO_CYC  = 40,
    parameter int CW_MIN      = 15,
    parameter int CW_MAX      = 1023,
    parameter int RETRY_LIMIT = 7,
    parameter int CW_W        = $clog2(CW_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chan_busy,
    input  logic            frame_req,
    input  logic            tx_done,
    input  logic            ack_rx,
    input  logic [CW_W-1:0] rnd_i,
    output logic            tx_grant,
    output logic            ack_timeout,
    output logic            tx_drop,
    output logic [CW_W-1:0] cw_o
);
    csma_state_e     state_q, state_d;
    csma_pulse_t     pulse_q, pulse_d;
    cw_op_e          cw_op;
    logic            difs_clr, difs_done;
    logic            slot_clr, slot_done;
    logic            bo_load, bo_dec, bo_last;
    logic [CW_W-1:0] bo_mask;
    logic            ack_start, ack_open, ack_expire;
    logic [CW_W-1:0] cw_cur, cw_grown;
    logic            last_try;

    assign difs_clr = (state_q != ST_DIFS);
    assign slot_clr = (state_q != ST_BACKOFF);
    // a retry draws its backoff from the window it is about to use
    assign bo_mask  = (state_q == ST_ACKWAIT) ? cw_grown : cw_cur;

    csma_idle_timer #(.LIMIT(DIFS_CYC)) u_difs (
        .clk  (clk),
        .rst  (rst),
        .clr  (difs_clr),
        .busy (chan_busy),
        .done (difs_done)
    );

    csma_idle_timer #(.LIMIT(SLOT_CYC)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .clr  (slot_clr),
        .busy (chan_busy),
        .done (slot_done)
    );

    csma_backoff_cnt #(.CW_W(CW_W)) u_bo (
        .clk  (clk),
        .rst  (rst),
        .load (bo_load),
        .rnd  (rnd_i),
        .mask (bo_mask),
        .dec  (bo_dec),
        .last (bo_last)
    );

    csma_ack_window #(.SIFS_CYC(SIFS_CYC), .ACK_TO_CYC(ACK_TO_CYC)) u_ackw (
        .clk      (clk),
        .rst      (rst),
        .start    (ack_start),
        .open_win (ack_open),
        .expire   (ack_expire)
    );

    csma_cw_reg #(
        .CW_W        (CW_W),
        .CW_MIN      (CW_MIN),
        .CW_MAX      (CW_MAX),
        .RETRY_LIMIT (RETRY_LIMIT)
    ) u_cw (
        .clk      (clk),
        .rst      (rst),
        .op       (cw_op),
        .cw       (cw_cur),
        .cw_grown (cw_grown),
        .last_try (last_try)
    );

    always_comb begin
        state_d   = state_q;
        pulse_d   = '0;
        cw_op     = CW_HOLD;
        bo_load   = 1'b0;
        bo_dec    = 1'b0;
        ack_start = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (frame_req) begin
                    bo_load = 1'b1;
                    state_d = ST_DIFS;
                end
            end
            ST_DIFS: begin
                if (difs_done) begin
                    state_d = ST_BACKOFF;
                end
            end
            ST_BACKOFF: begin
                if (chan_busy) begin
                    state_d = ST_DIFS;
                end else if (slot_done) begin
                    if (bo_last) begin
                        pulse_d.grant = 1'b1;
                        state_d       = ST_TXWAIT;
                    end else begin
                        bo_dec = 1'b1;
                    end
                end
            end
            ST_TXWAIT: begin
                if (tx_done) begin
                    ack_start = 1'b1;
                    state_d   = ST_ACKWAIT;
                end
            end
            ST_ACKWAIT: begin
                if (ack_rx && ack_open) begin
                    cw_op   = CW_RESET;
                    state_d = ST_IDLE;
                end else if (ack_expire) begin
                    pulse_d.tmo = 1'b1;
                    if (last_try) begin
                        pulse_d.drop = 1'b1;
                        cw_op        = CW_RESET;
                        state_d      = ST_IDLE;
                    end else begin
                        cw_op   = CW_GROW;
                        bo_load = 1'b1;
                        state_d = ST_DIFS;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
        end
    end

    assign tx_grant    = pulse_q.grant;
    assign ack_timeout = pulse_q.tmo;
    assign tx_drop     = pulse_q.drop;
    assign cw_o        = cw_cur;
endmodule

// File: rtl/csma_backoff_chk.sv
module csma_backoff_chk #(
    parameter int CW_W   = 10,
    parameter int CW_MIN = 15,
    parameter int CW_MAX = 1023
) (
    input logic            clk,
    input logic            rst,
    input logic            chan_busy,
    input logic            tx_grant,
    input logic            ack_timeout,
    input logic            tx_drop,
    input logic [CW_W-1:0] cw_o
);
    localparam logic [CW_W-1:0] MIN_V = CW_W'(CW_MIN);
    localparam logic [CW_W:0]   MAX_X = (CW_W+1)'(CW_MAX);

    logic [CW_W-1:0] cw_prev;
    logic [CW_W:0]   cw_dbl;
    logic [CW_W:0]   cw_exp;

    always_ff @(posedge clk) begin
        cw_prev <= cw_o;
    end

    assign cw_dbl = {cw_prev, 1'b1};
    assign cw_exp = (cw_dbl > MAX_X) ? MAX_X : cw_dbl;

    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_grant |=> !tx_grant); // R6

    AST_GRANT_NOT_TMO: assert property (@(posedge clk) disable iff (rst)
        !(tx_grant && ack_timeout)); // R6

    AST_GRANT_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_grant |-> !$past(chan_busy)); // R4

    AST_CW_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ((((CW_W+1)'(cw_o) + 1'b1) & (CW_W+1)'(cw_o)) == '0)
        && (cw_o >= MIN_V) && ((CW_W+1)'(cw_o) <= MAX_X)); // R9

    AST_TMO_GROW: assert property (@(posedge clk) disable iff (rst)
        (ack_timeout && !tx_drop) |-> ((CW_W+1)'(cw_o) == cw_exp)); // R8

    AST_DROP_PAIRED: assert property (@(posedge clk) disable iff (rst)
        tx_drop |-> ack_timeout); // R11

    AST_DROP_CW_MIN: assert property (@(posedge clk) disable iff (rst)
        tx_drop |-> (cw_o == MIN_V)); // R11
endmodule

bind csma_backoff_ctrl csma_backoff_chk #(
    .CW_W   (CW_W),
    .CW_MIN (CW_MIN),
    .CW_MAX (CW_MAX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chan_busy   (chan_busy),
    .tx_grant    (tx_grant),
    .ack_timeout (ack_timeout),
    .tx_drop     (tx_drop),
    .cw_o        (cw_o)
);

// File: tb/csma_backoff_ctrl_tb.sv
module csma_backoff_ctrl_tb_top;
    localparam int DIFS  = 6;
    localparam int SIFS  = 2;
    localparam int SLOT  = 3;
    localparam int ACKTO = 5;
    localparam int RLIM  = 10;
    localparam int CWW   = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           chan_busy = 1'b0;
    logic           frame_req = 1'b0;
    logic           tx_done = 1'b0;
    logic           ack_rx = 1'b0;
    logic [CWW-1:0] rnd_i = '0;
    logic           tx_grant, ack_timeout, tx_drop;
    logic [CWW-1:0] cw_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    int         q_cyc[$];
    logic [2:0] q_flag[$];
    string      q_tag[$];

    csma_backoff_ctrl #(
        .DIFS_CYC    (DIFS),
        .SIFS_CYC    (SIFS),
        .SLOT_CYC    (SLOT),
        .ACK_TO_CYC  (ACKTO),
        .CW_MIN      (15),
        .CW_MAX      (1023),
        .RETRY_LIMIT (RLIM),
        .CW_W        (CWW)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .chan_busy   (chan_busy),
        .frame_req   (frame_req),
        .tx_done     (tx_done),
        .ack_rx      (ack_rx),
        .rnd_i       (rnd_i),
        .tx_grant    (tx_grant),
        .ack_timeout (ack_timeout),
        .tx_drop     (tx_drop),
        .cw_o        (cw_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // flags: bit2 drop, bit1 timeout, bit0 grant
    task automatic push(input logic [2:0] f, input int c, input string tag);
        q_cyc.push_back(c);
        q_flag.push_back(f);
        q_tag.push_back(tag);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic request(input logic [CWW-1:0] r, output int e0);
        rnd_i     = r;
        frame_req = 1'b1;
        e0        = cyc + 1;
        @(negedge clk);
        frame_req = 1'b0;
    endtask

    task automatic busy_edges(input int first, input int n);
        wait_cyc(first - 1);
        chan_busy = 1'b1;
        repeat (n) @(negedge clk);
        chan_busy = 1'b0;
    endtask

    // tx_done right after the grant; ack at edge t0+ack_j when ack_j > 0
    task automatic send(input int g, input int ack_j, output int t0);
        wait_cyc(g);
        tx_done = 1'b1;
        t0      = cyc + 1;
        @(negedge clk);
        tx_done = 1'b0;
        if (ack_j > 0) begin
            wait_cyc(t0 + ack_j - 1);
            ack_rx = 1'b1;
            @(negedge clk);
            ack_rx = 1'b0;
        end
    endtask

    // monitor: every pulse must match the queue head in pattern and cycle
    always @(negedge clk) begin
        if (!rst && (tx_grant || ack_timeout || tx_drop)) begin
            if (q_cyc.size() == 0) begin
                check(1'b0, "R6 unexpected pulse", int'({tx_drop, ack_timeout, tx_grant}), 0);
            end else begin
                int         ec;
                logic [2:0] ef;
                string      et;
                ec = q_cyc.pop_front();
                ef = q_flag.pop_front();
                et = q_tag.pop_front();
                check({tx_drop, ack_timeout, tx_grant} == ef, {et, " flags"},
                      int'({tx_drop, ack_timeout, tx_grant}), int'(ef));
                check(cyc == ec, {et, " cycle"}, cyc, ec);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e0, t0, g, tmo, exp_cw;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!tx_grant && !ack_timeout && !tx_drop, "R1 pulses in reset", 0, 0);
        check(cw_o == 15, "R1 cw in reset", cw_o, 15);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_grant && !ack_timeout && !tx_drop, "R1 pulses after reset", 0, 0);

        // R2/R5: rnd 0 forced to one slot
        request(10'h000, e0);
        g = e0 + DIFS + 1 * SLOT;
        push(3'b001, g, "R2 R5 zero draw");
        send(g, SIFS, t0);
        wait_cyc(t0 + SIFS + 1);
        check(cw_o == 15, "R10 cw after ack", cw_o, 15);

        // R5 masking: 0x3F5 & 15 = 5 slots; ack at last legal edge (R7)
        request(10'h3F5, e0);
        g = e0 + DIFS + 5 * SLOT;
        push(3'b001, g, "R5 masked draw");
        send(g, SIFS + ACKTO, t0);
        wait_cyc(t0 + SIFS + ACKTO + 4);
        check(cw_o == 15, "R7 late-edge ack accepted", cw_o, 15);

        // R3: busy inside DIFS, last busy edge e0+4, two slots
        request(10'h002, e0);
        g = e0 + 4 + DIFS + 2 * SLOT;
        push(3'b001, g, "R3 difs restart");
        busy_edges(e0 + 3, 2);
        send(g, SIFS, t0);

        // R4: busy after first slot of three; two slots remain
        wait_cyc(t0 + SIFS + 1);
        request(10'h003, e0);
        g = e0 + DIFS + 5 + DIFS + 2 * SLOT;
        push(3'b001, g, "R4 freeze backoff");
        busy_edges(e0 + DIFS + 4, 2);
        send(g, SIFS, t0);

        // R7/R8: early ack ignored, timeout, grown window, retry grant
        wait_cyc(t0 + SIFS + 1);
        request(10'h000, e0);
        g = e0 + DIFS + SLOT;
        push(3'b001, g, "R2 grant");
        send(g, 1, t0);
        tmo = t0 + SIFS + ACKTO;
        push(3'b010, tmo, "R7 R8 timeout after early ack");
        push(3'b001, tmo + DIFS + SLOT, "R8 retry grant");
        wait_cyc(tmo);
        check(cw_o == 31, "R8 cw grown", cw_o, 31);
        send(tmo + DIFS + SLOT, SIFS, t0);
        wait_cyc(t0 + SIFS + 1);
        check(cw_o == 15, "R10 cw reset on ack", cw_o, 15);

        // R9/R11: repeated loss up to the retry limit
        request(10'h000, e0);
        g = e0 + DIFS + SLOT;
        push(3'b001, g, "R11 first grant");
        exp_cw = 15;
        for (int k = 1; k <= RLIM; k++) begin
            send(g, 0, t0);
            tmo = t0 + SIFS + ACKTO;
            if (k == RLIM) begin
                push(3'b110, tmo, "R11 drop");
            end else begin
                push(3'b010, tmo, "R8 timeout");
                exp_cw = (2 * exp_cw + 1 > 1023) ? 1023 : 2 * exp_cw + 1;
                g = tmo + DIFS + SLOT;
                push(3'b001, g, "R8 regrant");
            end
            wait_cyc(tmo);
            if (k == RLIM) begin
                check(cw_o == 15, "R11 cw after drop", cw_o, 15);
            end else begin
                check(cw_o == exp_cw, "R9 cw growth", cw_o, exp_cw);
            end
        end
        // R11: idle afterwards, no further pulses
        repeat (DIFS + 4 * SLOT) @(negedge clk);
        check(q_cyc.size() == 0, "R11 queue drained", q_cyc.size(), 0);
        check(cw_o == 15, "R11 cw stays min", cw_o, 15);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule